// File: doc/BRIEF.md
# Float to Extended-Format Unpacker

This block takes a raw IEEE-754 operand, either a 32-bit single or a 64-bit double, and produces the internal extended representation used by a floating-point datapath. That representation has a sign bit, a 15-bit exponent carrying the extended bias of 16383, and a 64-bit mantissa. The leading integer bit of the mantissa is stored explicitly and sits left-aligned at bit 63. Alongside the value, the block raises one of three classification flags: zero, special (infinity or NaN), or denormal.

The operand arrives on a 64-bit word together with a one-bit format select. A single operand occupies the low 32 bits of that word. Both formats are decoded side by side, and the format select picks one result. The result is captured in one register stage, qualified by a valid strobe. While no new operand is offered, the registered result stays as it is. Denormal inputs are flagged only. They are not normalised.

Top module: `fpx_unpack`

## Requirements
- R1: The result appears exactly one clock after `in_valid` is sampled high, and `out_valid` is `in_valid` delayed by one cycle. A synchronous reset (`rst` high) clears `out_valid` and every data and flag output to zero.
- R2: With `in_fmt`=0 (single), the sign is taken from bit 31, the biased exponent from bits 30:23 and the fraction from bits 22:0. Bits 63:32 of `in_word` have no effect on any output.
- R3: For a single operand that is neither zero nor denormal, `out_mant` holds the 24-bit significand {1, fraction} in bits 63:40. Bits 39:0 are zero.
- R4: With `in_fmt`=1 (double), the sign is taken from bit 63, the exponent from bits 62:52 and the fraction from bits 51:0. When the operand is neither zero nor denormal, `out_mant` holds {1, fraction} in bits 63:11, and bits 10:0 are zero.
- R5: A source exponent that is neither all-zeros nor all-ones is rebiased. `out_exp` is the field plus 16256 for single and the field plus 15360 for double.
- R6: An all-ones source exponent (0xFF for single, 0x7FF for double, so that all eleven bits must be set) gives `out_exp`=0x7FFF and `out_special`=1. The mantissa keeps the explicit leading one together with the fraction.
- R7: A zero exponent with a zero fraction gives `out_zero`=1, `out_exp`=0 and `out_mant`=0, with no hidden bit. The sign bit is passed through.
- R8: A zero exponent with a nonzero fraction gives `out_denorm`=1. Mantissa bit 63 stays clear, the fraction stays in its usual position, and `out_exp` is the rebias constant (16256 or 15360).
- R9: At most one of `out_zero`, `out_special` and `out_denorm` is set. All three are clear for a normal operand.
- R10: While `in_valid` is low, every data and flag output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand offered this cycle |
| in_fmt | input | 1 | 0 = single (low 32 bits), 1 = double |
| in_word | input | 64 | Raw operand bits |
| out_valid | output | 1 | Registered result is new this cycle |
| out_sign | output | 1 | Unpacked sign |
| out_exp | output | 15 | Exponent in extended bias, 0x7FFF for special |
| out_mant | output | 64 | Left-aligned mantissa with explicit integer bit |
| out_zero | output | 1 | Operand is a signed zero |
| out_special | output | 1 | Operand had an all-ones exponent |
| out_denorm | output | 1 | Operand had a zero exponent and a nonzero fraction |

## Verification
The bench feeds normal values in both formats, including 1.0, negative values and the extremes of the exponent range. With these patterns, a wrong rebias constant and a misplaced fraction field show up as separate failures. All-ones exponents, both infinity and NaN, are applied in both formats, so the special code and the retained fraction are checked on their own. A double with exponent 0x3FF must not be classified as special. Positive and negative zero are contrasted with the smallest denormals in each format, which separates clearing the hidden bit from zeroing the mantissa. Finally, garbage in the upper half of a single operand and idle cycles carrying different words confirm that unused bits and unqualified inputs leave the outputs untouched.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int EXT_EXP_W = 15;
    localparam int MANT_W    = 64;
    localparam int EXT_BIAS  = 16383;
    localparam int NUM_FMT   = 2;
    localparam int WORD_W    = 64;

    localparam logic [EXT_EXP_W-1:0] EXP_SPECIAL = '1;

    typedef enum logic {
        FMT_SINGLE = 1'b0,
        FMT_DOUBLE = 1'b1
    } fmt_e;

    typedef struct packed {
        logic                 sign;
        logic [EXT_EXP_W-1:0] exp;
        logic [MANT_W-1:0]    mant;
        logic                 zero;
        logic                 special;
        logic                 denorm;
    } xval_t;

    function automatic int src_exp_w(input int f);
        return (f == 0) ? 8 : 11;
    endfunction

    function automatic int src_frac_w(input int f);
        return (f == 0) ? 23 : 52;
    endfunction

    function automatic int src_bias(input int f);
        return (f == 0) ? 127 : 1023;
    endfunction

endpackage

// File: rtl/fpx_fmt_decode.sv
module fpx_fmt_decode
    import fpx_pkg::*;
#(
    parameter int EXP_W    = 8,
    parameter int FRAC_W   = 23,
    parameter int SRC_BIAS = 127,
    localparam int SRC_W   = 1 + EXP_W + FRAC_W
) (
    input  logic [SRC_W-1:0] src,
    output xval_t            xv
);

    localparam logic [EXT_EXP_W-1:0] REBIAS = EXT_EXP_W'(EXT_BIAS - SRC_BIAS);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_nz;

    assign exp_f    = src[SRC_W-2 -: EXP_W];
    assign frac_f   = src[FRAC_W-1:0];
    assign exp_ones = &exp_f;
    assign exp_zero = ~|exp_f;
    assign frac_nz  = |frac_f;

    always_comb begin
        xv      = '0;
        xv.sign = src[SRC_W-1];
        if (exp_zero && !frac_nz) begin
            // signed zero: no hidden bit, no rebias
            xv.zero = 1'b1;
        end else begin
            xv.mant[MANT_W-1]            = !exp_zero;
            xv.mant[MANT_W-2 -: FRAC_W]  = frac_f;
            if (exp_ones) begin
                xv.exp     = EXP_SPECIAL;
                xv.special = 1'b1;
            end else begin
                xv.exp    = EXT_EXP_W'(exp_f) + REBIAS;
                xv.denorm = exp_zero;
            end
        end
    end

endmodule

// File: rtl/fpx_fmt_select.sv
module fpx_fmt_select
    import fpx_pkg::*;
(
    input  xval_t cand [NUM_FMT],
    input  logic  fmt,
    output xval_t sel
);

    always_comb begin
        sel = cand[0];
        for (int i = 1; i < NUM_FMT; i++) begin
            if (int'(fmt) == i) sel = cand[i];
        end
    end

endmodule

// File: rtl/fpx_stage.sv
module fpx_stage
    import fpx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld,
    input  xval_t d,
    output xval_t q,
    output logic  q_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= ld;
            if (ld) q <= d;
        end
    end

endmodule

// File: rtl/fpx_unpack.sv
module fpx_unpack
    import fpx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_fmt,
    input  logic [WORD_W-1:0]    in_word,
    output logic                 out_valid,
    output logic                 out_sign,
    output logic [EXT_EXP_W-1:0] out_exp,
    output logic [MANT_W-1:0]    out_mant,
    output logic                 out_zero,
    output logic                 out_special,
    output logic                 out_denorm
);

    xval_t cand [NUM_FMT];
    xval_t picked;
    xval_t held;

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int EW = src_exp_w(g);
        localparam int FW = src_frac_w(g);
        localparam int SW = 1 + EW + FW;
        fpx_fmt_decode #(
            .EXP_W   (EW),
            .FRAC_W  (FW),
            .SRC_BIAS(src_bias(g))
        ) u_dec (
            .src(in_word[SW-1:0]),
            .xv (cand[g])
        );
    end

    fpx_fmt_select u_sel (
        .cand(cand),
        .fmt (in_fmt),
        .sel (picked)
    );

    fpx_stage u_stage (
        .clk    (clk),
        .rst    (rst),
        .ld     (in_valid),
        .d      (picked),
        .q      (held),
        .q_valid(out_valid)
    );

    assign out_sign    = held.sign;
    assign out_exp     = held.exp;
    assign out_mant    = held.mant;
    assign out_zero    = held.zero;
    assign out_special = held.special;
    assign out_denorm  = held.denorm;

endmodule

// File: rtl/fpx_unpack_chk.sv
module fpx_unpack_chk
    import fpx_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_fmt,
    input logic                 out_valid,
    input logic                 out_sign,
    input logic [EXT_EXP_W-1:0] out_exp,
    input logic [MANT_W-1:0]    out_mant,
    input logic                 out_zero,
    input logic                 out_special,
    input logic                 out_denorm
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid) else $error("valid latency"); // R1
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid) else $error("spurious valid"); // R1
    AST_SINGLE_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == FMT_SINGLE) |=> (out_mant[39:0] == '0)) else $error("single low bits"); // R3
    AST_DOUBLE_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == FMT_DOUBLE) |=> (out_mant[10:0] == '0)) else $error("double low bits"); // R4
    AST_SPECIAL_CODE: assert property (@(posedge clk) disable iff (rst)
        out_special |-> (out_exp == EXP_SPECIAL && out_mant[MANT_W-1])) else $error("special code"); // R6
    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (rst)
        out_zero |-> (out_exp == '0 && out_mant == '0)) else $error("zero not clean"); // R7
    AST_DENORM_NO_LEAD: assert property (@(posedge clk) disable iff (rst)
        out_denorm |-> (!out_mant[MANT_W-1] && out_mant != '0)) else $error("denorm lead"); // R8
    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_zero, out_special, out_denorm})) else $error("flags overlap"); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_exp) && $stable(out_mant) && $stable(out_sign)
                       && $stable({out_zero, out_special, out_denorm}))) else $error("hold"); // R10

endmodule

bind fpx_unpack fpx_unpack_chk u_chk (.*);

// File: tb/fpx_unpack_bench.sv
module fpx_unpack_bench;

    localparam int CLK_P = 10;
    localparam int WATCHDOG_CYC = 5000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_fmt;
    logic [63:0] in_word;
    logic        out_valid;
    logic        out_sign;
    logic [14:0] out_exp;
    logic [63:0] out_mant;
    logic        out_zero;
    logic        out_special;
    logic        out_denorm;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    fpx_unpack u_fpx_unpack (
        .clk, .rst, .in_valid, .in_fmt, .in_word,
        .out_valid, .out_sign, .out_exp, .out_mant,
        .out_zero, .out_special, .out_denorm
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check_out(input string req, input bit v, input bit s, input logic [14:0] e,
                             input logic [63:0] m, input bit z, input bit sp, input bit dn);
        n_checks++;
        if (out_valid !== v || out_sign !== s || out_exp !== e || out_mant !== m ||
            out_zero !== z || out_special !== sp || out_denorm !== dn) begin
            n_errors++;
            $display("FAIL %s: actual v=%0b s=%0b e=%h m=%h z=%0b sp=%0b dn=%0b expected v=%0b s=%0b e=%h m=%h z=%0b sp=%0b dn=%0b",
                     req, out_valid, out_sign, out_exp, out_mant, out_zero, out_special, out_denorm,
                     v, s, e, m, z, sp, dn);
        end
    endtask

    // drive one operand, sample one cycle later away from the edge
    task automatic apply(input bit fmt, input logic [63:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_fmt   = fmt;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; in_fmt = 1'b0; in_word = '0;
        repeat (3) @(negedge clk);
        check_out("R1 reset", 0, 0, 15'h0, 64'h0, 0, 0, 0);
        rst = 1'b0;
    endtask

    task automatic t_single_normal;
        apply(1'b0, 64'h0000_0000_3F80_0000);
        check_out("R1 R2 R3 R5 single 1.0", 1, 0, 15'h3FFF, 64'h8000_0000_0000_0000, 0, 0, 0);
        apply(1'b0, 64'h0000_0000_C020_0000);
        check_out("R2 R3 R5 single -2.5", 1, 1, 15'h4000, 64'hA000_0000_0000_0000, 0, 0, 0);
        apply(1'b0, 64'h0000_0000_7F7F_FFFF);
        check_out("R3 R5 R9 single max", 1, 0, 15'h407E, 64'hFFFF_FF00_0000_0000, 0, 0, 0);
    endtask

    task automatic t_double_normal;
        apply(1'b1, 64'h3FF0_0000_0000_0000);
        check_out("R4 R5 R6 double 1.0 not special", 1, 0, 15'h3FFF, 64'h8000_0000_0000_0000, 0, 0, 0);
        apply(1'b1, 64'hC008_0000_0000_0000);
        check_out("R4 R5 double -3.0", 1, 1, 15'h4000, 64'hC000_0000_0000_0000, 0, 0, 0);
        apply(1'b1, 64'h0010_0000_0000_0001);
        check_out("R4 R5 double min normal", 1, 0, 15'h3C01, 64'h8000_0000_0000_0800, 0, 0, 0);
    endtask

    task automatic t_special;
        apply(1'b0, 64'h0000_0000_7F80_0000);
        check_out("R6 single inf", 1, 0, 15'h7FFF, 64'h8000_0000_0000_0000, 0, 1, 0);
        apply(1'b0, 64'h0000_0000_7FC0_0001);
        check_out("R6 single nan", 1, 0, 15'h7FFF, 64'hC000_0100_0000_0000, 0, 1, 0);
        apply(1'b1, 64'hFFF0_0000_0000_0000);
        check_out("R6 double -inf", 1, 1, 15'h7FFF, 64'h8000_0000_0000_0000, 0, 1, 0);
    endtask

    task automatic t_zero;
        apply(1'b0, 64'h0);
        check_out("R7 single +0", 1, 0, 15'h0, 64'h0, 1, 0, 0);
        apply(1'b0, 64'h0000_0000_8000_0000);
        check_out("R7 single -0", 1, 1, 15'h0, 64'h0, 1, 0, 0);
        apply(1'b1, 64'h0);
        check_out("R7 double +0", 1, 0, 15'h0, 64'h0, 1, 0, 0);
    endtask

    task automatic t_denorm;
        apply(1'b0, 64'h0000_0000_0000_0001);
        check_out("R8 single min denorm", 1, 0, 15'h3F80, 64'h0000_0100_0000_0000, 0, 0, 1);
        apply(1'b1, 64'h000F_FFFF_FFFF_FFFF);
        check_out("R8 double max denorm", 1, 0, 15'h3C00, 64'h7FFF_FFFF_FFFF_F800, 0, 0, 1);
    endtask

    task automatic t_upper_ignored;
        apply(1'b0, 64'hDEAD_BEEF_3F80_0000);
        check_out("R2 upper bits ignored", 1, 0, 15'h3FFF, 64'h8000_0000_0000_0000, 0, 0, 0);
        apply(1'b0, 64'hFFFF_FFFF_0000_0000);
        check_out("R2 upper bits ignored zero", 1, 0, 15'h0, 64'h0, 1, 0, 0);
    endtask

    task automatic t_hold;
        apply(1'b1, 64'hC008_0000_0000_0000);
        @(negedge clk);
        in_fmt  = 1'b0;
        in_word = 64'h0000_0000_7F80_0000;
        repeat (3) @(negedge clk);
        check_out("R10 hold while idle", 0, 1, 15'h4000, 64'hC000_0000_0000_0000, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_single_normal();
        t_double_normal();
        t_special();
        t_zero();
        t_denorm();
        t_upper_ignored();
        t_hold();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < WATCHDOG_CYC && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule